// File: doc/BRIEF.md
# Programmable Chip-Select Cycle Controller

This block looks after one address region of an external memory bus. A main configuration register holds the region's base address, its size, its data width, the upper three bits of its wait count, a flash-timing flag and an enable. A separate control register holds the low bit of the wait count. When an address strobe arrives while the block is idle, the address is compared with the region. On a hit the block drives an active-low chip select for the whole bus cycle. For writes it also drives active-low lower and upper write strobes. It then either counts the programmed wait states and raises an internal acknowledge, or waits for an external acknowledge input.

The wait count is four bits wide. The upper three bits step in twos and the lower bit adds one, which gives 0 to 13 wait states. The all-ones upper code hands termination to the external acknowledge. In flash timing, a write keeps its strobes off for the first clock of chip select. The cycle is then lengthened by one clock, so the strobes still last the full programmed time. Configuration writes are accepted only while no cycle is running.

Top module: `cs_cycle_ctrl`

## Requirements
- R1: After reset, `cs_n`, `lwe_n` and `uwe_n` are high, `int_ack` is low, and the region is disabled, so an address strobe produces no chip select.
- R2: With wait upper code below 7, the wait count is W = 2*upper + low. `cs_n` stays low for W+1 clocks (W+2 for a flash-timed write). `int_ack` is high for exactly one clock, the last low clock of `cs_n`. `cs_n` rises on the clock after that, and the block is idle again.
- R3: With wait upper code 7, `int_ack` never asserts. `cs_n` rises on the clock after `ext_ack` is sampled high. For a flash-timed write, `ext_ack` is honoured only once the strobes are active.
- R4: With the flash flag 0, write strobes go low on the same clock edge as `cs_n`. With the flash flag 1, they go low one clock later. Either way they stay low until `cs_n` rises.
- R5: With the width bit 0 (8-bit), every write drives `lwe_n` low whatever `bus_be` holds, and `uwe_n` stays high.
- R6: With the width bit 1 (16-bit), `lwe_n` is driven on a write only if `bus_be[0]` is 1, and `uwe_n` only if `bus_be[1]` is 1.
- R7: Read cycles (`bus_write` 0) assert `cs_n` with the same length as R2/R3 without the flash extension, and both write strobes stay high.
- R8: The size code s (0..7) selects a region of 2^(17+s) bytes. An address hits when its bits from position 17+s upward equal those of the base address.
- R9: While the enable bit is 0, `cs_n` never asserts.
- R10: Configuration writes issued while a cycle is running are discarded. Those issued while idle take effect at the next clock edge.
- R11: `data_wide` shows the region's stored width bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_main_we | input | 1 | Write strobe for the main configuration register |
| cfg_base | input | ADDR_W | Region base address |
| cfg_size | input | 3 | Region size code |
| cfg_wide | input | 1 | Data width: 0 = 8-bit, 1 = 16-bit |
| cfg_wait_hi | input | 3 | Upper wait-count bits; 7 = external acknowledge |
| cfg_flash | input | 1 | Delay write strobes one clock behind chip select |
| cfg_en | input | 1 | Region enable |
| cfg_ctrl_we | input | 1 | Write strobe for the control register |
| cfg_wait_lo | input | 1 | Low wait-count bit |
| bus_as | input | 1 | Address strobe, starts a cycle when idle |
| bus_addr | input | ADDR_W | Bus address |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_be | input | 2 | Byte enables: bit 0 lower, bit 1 upper |
| ext_ack | input | 1 | External acknowledge |
| cs_n | output | 1 | Active-low chip select |
| lwe_n | output | 1 | Active-low lower write strobe |
| uwe_n | output | 1 | Active-low upper write strobe |
| int_ack | output | 1 | Internal acknowledge, one clock at cycle end |
| data_wide | output | 1 | Stored width bit of the region |

## Verification
The hardest situation to reach from the ports is a configuration write that lands in the middle of a running cycle. It must leave both that cycle and later ones unchanged. The stimulus starts a long cycle and pulses both configuration strobes during its third clock, with values that would disable the region and shorten the wait. It then runs a further cycle to show that the old settings survived. Flash-timed writes with an early external acknowledge are a second corner. The sweep raises `ext_ack` on the very first clock of chip select and expects the cycle to run until the strobes have been active.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam logic [2:0] WAIT_EXT_CODE = 3'b111;

  function automatic logic [3:0] wait_count(input logic [2:0] hi, input logic lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/cs_addr_match.sv
module cs_addr_match #(
  parameter int ADDR_W   = 24,
  parameter int MIN_LOG2 = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [2:0]        size,
  output logic              hit
);
  logic [ADDR_W-1:0] keep;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_keep
    assign keep[b] = (32'(b) >= (32'(MIN_LOG2) + 32'(size)));
  end

  assign hit = (((addr ^ base) & keep) == '0);
endmodule

// File: rtl/cs_wait_ctr.sv
module cs_wait_ctr import cs_pkg::*; #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic [2:0]       wait_hi,
  input  logic             wait_lo,
  input  logic             extend,
  input  logic             ext_ack,
  output logic [CNT_W-1:0] cnt,
  output logic             int_ack,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d, target;
  logic             ext_mode, strobe_ok;

  assign ext_mode  = (wait_hi == WAIT_EXT_CODE);
  assign target    = CNT_W'(wait_count(wait_hi, wait_lo)) + CNT_W'(extend);
  assign strobe_ok = !extend || (cnt_q != '0);
  assign int_ack   = busy && !ext_mode && (cnt_q == target);
  assign done      = busy && (ext_mode ? (ext_ack && strobe_ok) : (cnt_q == target));
  assign cnt       = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = '0;
    else if (busy && !done && (cnt_q != '1))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cs_strobe_seq.sv
module cs_strobe_seq (
  input  logic       busy,
  input  logic       wr,
  input  logic [1:0] be,
  input  logic       wide,
  input  logic       flash,
  input  logic       past_first,
  output logic       cs_n,
  output logic       lwe_n,
  output logic       uwe_n
);
  logic strobe_phase;

  assign strobe_phase = busy && wr && (!flash || past_first);
  assign cs_n  = !busy;
  assign lwe_n = !(strobe_phase && (!wide || be[0]));
  assign uwe_n = !(strobe_phase && wide && be[1]);
endmodule

// File: rtl/cs_cycle_ctrl.sv
module cs_cycle_ctrl import cs_pkg::*; #(
  parameter int ADDR_W   = 24,
  parameter int MIN_LOG2 = 17,
  parameter int CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_main_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [2:0]        cfg_size,
  input  logic              cfg_wide,
  input  logic [2:0]        cfg_wait_hi,
  input  logic              cfg_flash,
  input  logic              cfg_en,
  input  logic              cfg_ctrl_we,
  input  logic              cfg_wait_lo,
  input  logic              bus_as,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [1:0]        bus_be,
  input  logic              ext_ack,
  output logic              cs_n,
  output logic              lwe_n,
  output logic              uwe_n,
  output logic              int_ack,
  output logic              data_wide
);
  logic [1:0] rst_pipe_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  logic [ADDR_W-1:0] cfg_base_q, cfg_base_d;
  logic [2:0]        cfg_size_q, cfg_size_d, cfg_wait_hi_q, cfg_wait_hi_d;
  logic              cfg_wide_q, cfg_wide_d, cfg_flash_q, cfg_flash_d;
  logic              cfg_en_q, cfg_en_d, cfg_wait_lo_q, cfg_wait_lo_d;
  logic              busy_q, busy_d, wr_q, wr_d;
  logic [1:0]        be_q, be_d;
  logic              main_ld, ctrl_ld, region_hit, start, cyc_done, extend;
  logic [CNT_W-1:0]  cnt;

  assign main_ld = cfg_main_we && !busy_q;
  assign ctrl_ld = cfg_ctrl_we && !busy_q;
  assign start   = !busy_q && bus_as && cfg_en_q && region_hit;
  assign extend  = cfg_flash_q && wr_q;

  always_comb begin
    cfg_base_d    = cfg_base_q;
    cfg_size_d    = cfg_size_q;
    cfg_wide_d    = cfg_wide_q;
    cfg_wait_hi_d = cfg_wait_hi_q;
    cfg_flash_d   = cfg_flash_q;
    cfg_en_d      = cfg_en_q;
    cfg_wait_lo_d = cfg_wait_lo_q;
    if (main_ld) begin
      cfg_base_d    = cfg_base;
      cfg_size_d    = cfg_size;
      cfg_wide_d    = cfg_wide;
      cfg_wait_hi_d = cfg_wait_hi;
      cfg_flash_d   = cfg_flash;
      cfg_en_d      = cfg_en;
    end
    if (ctrl_ld)
      cfg_wait_lo_d = cfg_wait_lo;
  end

  always_comb begin
    busy_d = busy_q;
    wr_d   = wr_q;
    be_d   = be_q;
    if (start) begin
      busy_d = 1'b1;
      wr_d   = bus_write;
      be_d   = bus_be;
    end else if (cyc_done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cfg_base_q    <= '0;
      cfg_size_q    <= '0;
      cfg_wide_q    <= 1'b0;
      cfg_wait_hi_q <= '0;
      cfg_flash_q   <= 1'b0;
      cfg_en_q      <= 1'b0;
      cfg_wait_lo_q <= 1'b0;
      busy_q        <= 1'b0;
      wr_q          <= 1'b0;
      be_q          <= '0;
    end else begin
      cfg_base_q    <= cfg_base_d;
      cfg_size_q    <= cfg_size_d;
      cfg_wide_q    <= cfg_wide_d;
      cfg_wait_hi_q <= cfg_wait_hi_d;
      cfg_flash_q   <= cfg_flash_d;
      cfg_en_q      <= cfg_en_d;
      cfg_wait_lo_q <= cfg_wait_lo_d;
      busy_q        <= busy_d;
      wr_q          <= wr_d;
      be_q          <= be_d;
    end
  end

  cs_addr_match #(.ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2)) i_match (
    .addr(bus_addr), .base(cfg_base_q), .size(cfg_size_q), .hit(region_hit)
  );

  cs_wait_ctr #(.CNT_W(CNT_W)) i_wait (
    .clk(clk), .rst_n(srst_n), .start(start), .busy(busy_q),
    .wait_hi(cfg_wait_hi_q), .wait_lo(cfg_wait_lo_q), .extend(extend),
    .ext_ack(ext_ack), .cnt(cnt), .int_ack(int_ack), .done(cyc_done)
  );

  cs_strobe_seq i_strobe (
    .busy(busy_q), .wr(wr_q), .be(be_q), .wide(cfg_wide_q),
    .flash(cfg_flash_q), .past_first(cnt != '0),
    .cs_n(cs_n), .lwe_n(lwe_n), .uwe_n(uwe_n)
  );

  assign data_wide = cfg_wide_q;
endmodule

// File: rtl/cs_cycle_ctrl_chk.sv
module cs_cycle_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       lwe_n,
  input logic       uwe_n,
  input logic       int_ack,
  input logic       data_wide,
  input logic       en,
  input logic       flash,
  input logic [2:0] wait_hi,
  input logic       wait_lo
);
  p_ack_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> !cs_n);
  p_ack_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> (cs_n && !int_ack));
  p_ext_no_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_hi == 3'b111) |-> !int_ack);
  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lwe_n || !uwe_n) |-> !cs_n);
  p_flash_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && flash) |-> (lwe_n && uwe_n));
  p_narrow_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wide |-> uwe_n);
  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> cs_n);
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> ($stable(wait_hi) && $stable(wait_lo) && $stable(flash) && $stable(en)));
endmodule

bind cs_cycle_ctrl cs_cycle_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .lwe_n(lwe_n), .uwe_n(uwe_n),
  .int_ack(int_ack), .data_wide(data_wide), .en(cfg_en_q), .flash(cfg_flash_q),
  .wait_hi(cfg_wait_hi_q), .wait_lo(cfg_wait_lo_q)
);

// File: tb/test_cs_cycle_ctrl.sv
`timescale 1ns/1ps
module test_cs_cycle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_main_we = 1'b0, cfg_ctrl_we = 1'b0;
  logic [23:0] cfg_base = '0;
  logic [2:0]  cfg_size = '0, cfg_wait_hi = '0;
  logic        cfg_wide = 1'b0, cfg_flash = 1'b0, cfg_en = 1'b0, cfg_wait_lo = 1'b0;
  logic        bus_as = 1'b0, bus_write = 1'b0, ext_ack = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic        cs_n, lwe_n, uwe_n, int_ack, data_wide;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  cs_cycle_ctrl i_cs_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_main_we(cfg_main_we), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_wide(cfg_wide), .cfg_wait_hi(cfg_wait_hi),
    .cfg_flash(cfg_flash), .cfg_en(cfg_en), .cfg_ctrl_we(cfg_ctrl_we),
    .cfg_wait_lo(cfg_wait_lo), .bus_as(bus_as), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_be(bus_be), .ext_ack(ext_ack), .cs_n(cs_n),
    .lwe_n(lwe_n), .uwe_n(uwe_n), .int_ack(int_ack), .data_wide(data_wide)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_main(input logic [23:0] base, input logic [2:0] size, input logic wide,
                          input logic [2:0] hi, input logic fl, input logic en);
    @(negedge clk);
    cfg_base = base; cfg_size = size; cfg_wide = wide; cfg_wait_hi = hi;
    cfg_flash = fl; cfg_en = en; cfg_main_we = 1'b1;
    @(negedge clk);
    cfg_main_we = 1'b0;
  endtask

  task automatic set_ctrl(input logic lo);
    @(negedge clk);
    cfg_wait_lo = lo; cfg_ctrl_we = 1'b1;
    @(negedge clk);
    cfg_ctrl_we = 1'b0;
  endtask

  // Launch one address strobe and record what the outputs do until cs_n rises.
  task automatic run_cycle(input logic [23:0] addr, input logic wr, input logic [1:0] be,
                           input int ext_k, input bit mid_cfg,
                           output int len, output int acks, output int ack_idx,
                           output int lw, output int lw_first, output int uw, output int uw_first);
    len = 0; acks = 0; ack_idx = -1; lw = 0; lw_first = -1; uw = 0; uw_first = -1;
    @(negedge clk);
    bus_as = 1'b1; bus_addr = addr; bus_write = wr; bus_be = be;
    @(negedge clk);
    bus_as = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (ext_k >= 0 && i >= ext_k) ext_ack = 1'b1;
      if (mid_cfg && i == 2) begin
        cfg_en = 1'b0; cfg_wait_hi = 3'd0; cfg_wait_lo = 1'b1;
        cfg_main_we = 1'b1; cfg_ctrl_we = 1'b1;
      end else begin
        cfg_main_we = 1'b0; cfg_ctrl_we = 1'b0;
      end
      if (cs_n) break;
      len++;
      if (int_ack) begin acks++; ack_idx = i; end
      if (!lwe_n) begin lw++; if (lw_first < 0) lw_first = i; end
      if (!uwe_n) begin uw++; if (uw_first < 0) uw_first = i; end
      @(negedge clk);
    end
    ext_ack = 1'b0; cfg_main_we = 1'b0; cfg_ctrl_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int len, acks, aidx, lw, lwf, uw, uwf;
    logic [23:0] base;
    base = 24'h800000;

    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", int'(cs_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cs_n idle", int'(cs_n), 1);
    chk("R1 lwe_n idle", int'(lwe_n), 1);
    chk("R1 uwe_n idle", int'(uwe_n), 1);
    chk("R1 int_ack idle", int'(int_ack), 0);
    run_cycle(24'h000005, 1'b1, 2'b11, -1, 1'b0, len, acks, aidx, lw, lwf, uw, uwf);
    chk("R1 disabled after reset", len, 0);

    // Timing sweep over wait codes, flash, width, direction and byte enables
    for (int hi = 0; hi < 8; hi++)
      for (int lo = 0; lo < 2; lo++)
        for (int fl = 0; fl < 2; fl++)
          for (int wd = 0; wd < 2; wd++)
            for (int wr = 0; wr < 2; wr++)
              for (int bi = 1; bi < 4; bi++) begin
                int f, w, k, elen, lwe_exp, uwe_exp;
                logic [1:0] be;
                bit ext;
                set_main(base, 3'd0, wd[0], hi[2:0], fl[0], 1'b1);
                set_ctrl(lo[0]);
                chk("R11 data_wide", int'(data_wide), wd);
                be  = bi[1:0];
                f   = (fl == 1 && wr == 1) ? 1 : 0;
                ext = (hi == 7);
                w   = hi * 2 + lo;
                k   = lo * 3 + ((bi == 2) ? 0 : fl);
                run_cycle(base + 24'd5, wr[0], be, ext ? k : -1, 1'b0,
                          len, acks, aidx, lw, lwf, uw, uwf);
                if (ext) begin
                  elen = ((k > f) ? k : f) + 1;
                  chk("R3 ext length", len, elen);
                  chk("R3 no int_ack", acks, 0);
                end else begin
                  elen = w + 1 + f;
                  chk("R2 length", len, elen);
                  chk("R2 int_ack count", acks, 1);
                  chk("R2 int_ack last clock", aidx, elen - 1);
                end
                lwe_exp = (wr == 1 && (wd == 0 || be[0])) ? elen - f : 0;
                uwe_exp = (wr == 1 && wd == 1 && be[1]) ? elen - f : 0;
                if (wr == 0) begin
                  chk("R7 read lwe", lw, 0);
                  chk("R7 read uwe", uw, 0);
                end else if (wd == 0) begin
                  chk("R5 lwe clocks", lw, lwe_exp);
                  chk("R5 uwe quiet", uw, 0);
                end else begin
                  chk("R6 lwe clocks", lw, lwe_exp);
                  chk("R6 uwe clocks", uw, uwe_exp);
                end
                if (lwe_exp > 0) chk("R4 lwe start", lwf, f);
                if (uwe_exp > 0) chk("R4 uwe start", uwf, f);
              end

    // Address matching over all size codes
    set_ctrl(1'b0);
    for (int s = 0; s < 8; s++) begin
      int sh;
      logic [23:0] sz;
      sh = 17 + s;
      sz = 24'(32'd1 << sh);
      set_main(base, s[2:0], 1'b0, 3'd0, 1'b0, 1'b1);
      for (int j = 0; j < 5; j++) begin
        logic [23:0] a;
        int exp_hit;
        case (j)
          0: a = base - 24'd1;
          1: a = base;
          2: a = base + sz - 24'd1;
          3: a = base + sz;
          default: a = 24'h000000;
        endcase
        exp_hit = ((32'(a) >> sh) == (32'(base) >> sh)) ? 1 : 0;
        run_cycle(a, 1'b0, 2'b00, -1, 1'b0, len, acks, aidx, lw, lwf, uw, uwf);
        chk("R8 match", len, exp_hit);
      end
    end

    // Enable off
    set_main(base, 3'd0, 1'b1, 3'd0, 1'b0, 1'b0);
    run_cycle(base, 1'b1, 2'b11, -1, 1'b0, len, acks, aidx, lw, lwf, uw, uwf);
    chk("R9 disabled no cs", len, 0);

    // Configuration writes during a running cycle are discarded
    set_main(base, 3'd0, 1'b1, 3'd3, 1'b0, 1'b1);
    set_ctrl(1'b0);
    run_cycle(base, 1'b1, 2'b11, -1, 1'b1, len, acks, aidx, lw, lwf, uw, uwf);
    chk("R10 running cycle length", len, 7);
    run_cycle(base, 1'b1, 2'b11, -1, 1'b0, len, acks, aidx, lw, lwf, uw, uwf);
    chk("R10 settings kept", len, 7);
    set_ctrl(1'b1);
    run_cycle(base, 1'b0, 2'b00, -1, 1'b0, len, acks, aidx, lw, lwf, uw, uwf);
    chk("R10 idle write applied", len, 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule